// File: doc/BRIEF.md
# Offset-Binary Distributed-Arithmetic Inner Product

This block forms the inner product of four signed fixed-point coefficients and four signed two's-complement samples. It uses no multiplier. Each sample bit is recoded as a signed digit of +1 or -1, so every bit slice contributes a signed half-sum of the coefficients. The block then weights these half-sums by powers of two in a shifting accumulator. It handles one bit position per clock. It starts at the least significant slice and ends at the sign slice, so one product takes N cycles after the start cycle.

A pulse on `start` while the block is idle captures the coefficients and samples and preloads the accumulator with the constant offset term. The block then steps through the slices, and `done_o` rises for one cycle when the last slice has been added. `clr` zeroes the accumulator at any time and abandons a product that is in progress. A compile-time parameter selects how the per-slice half-sum is produced:

- a half-size table with sign mirroring;
- two small tables joined by one adder;
- a table-free adder tree.

All three give bit-identical results.

Top module: `obc_da_mac`

## Requirements
- R1: After a product completes, `result_o` (CW+N+2 bits, signed) holds the exact value of a0·x0 + a1·x1 + a2·x2 + a3·x3. Coefficient k is `coef_i[k*CW +: CW]` (signed) and sample k is `smp_i[k*N +: N]` (signed two's complement). The value holds until the next start or clear.
- R2: `done_o` goes high in the cycle that follows the N-th rising edge after the edge that sampled an accepted `start`. It stays high for exactly one cycle.
- R3: Sample bit j of term k becomes digit +1 when the bit is 1 and -1 when it is 0, for j < N-1. For the sign bit (j = N-1) the mapping is reversed. Products of negative and positive samples therefore come out exact.
- R4: The slice value is the sum over k of (digit_k · a_k), carried as a half-value with one fraction bit. Bit k of the slice address is the bit of sample k. In the half-table variant, any address whose term-3 digit is +1 returns the negated entry of the bitwise complement address. For coefficients 2, 3, 4, 5 and digits -1, -1, +1, +1, the half-value is 2.
- R5: The half-table, two-bank and adder-tree variants produce identical `result_o` and `done_o` for identical stimulus.
- R6: A clock edge with `clr` high forces the accumulator and `result_o` to zero. It also ends any product in progress, so no `done_o` pulse follows.
- R7: `start` is ignored while a product is in progress. The running product, its completion time and its result are unaffected.
- R8: The offset term (minus half the coefficient sum, scaled by one slice weight) is loaded at start. As a result, all-zero samples give a zero result for any coefficients.
- R9: For full-range coefficients and samples, including all terms at the most negative value and odd coefficients, the result is exact, with no overflow or truncation.
- R10: Coefficients and samples are captured on the start edge. Changing `coef_i` or `smp_i` during a product has no effect on its result.
- R11: After reset, `result_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the accumulator; aborts a running product |
| start | input | 1 | Begin a product when idle |
| coef_i | input | 4*CW | Four signed coefficients, term k at bits k*CW +: CW |
| smp_i | input | 4*N | Four signed samples, term k at bits k*N +: N |
| result_o | output | CW+N+2 | Signed inner product |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
The hardest case to reach from the ports is the sign slice in which the reversed recoding lands on an address that uses the mirrored half of the table. This needs a sample whose sign bit is clear while term 3's lower bits differ from it, combined with odd coefficients whose half-values are fractional. The stimulus reaches it with mixed-sign and alternating-bit sample rows (0x5555 and 0xAAAA patterns, most negative and most positive values) against odd and extreme coefficients. Three instances, one per variant, see the same drive. Separate runs inject a second start and changed inputs partway through a product, and another run pulses clear mid-product. Each of these runs then checks that the completion time and result are unchanged, or that no completion follows.

// File: rtl/obc_da_pkg.sv
package obc_da_pkg;

  localparam int NTERMS = 4;

  typedef enum logic [1:0] {
    GEN_HALF_TABLE = 2'd0,
    GEN_TWO_BANK   = 2'd1,
    GEN_ADDER_TREE = 2'd2
  } gen_e;

endpackage

// File: rtl/obc_da_seq.sv
module obc_da_seq
  import obc_da_pkg::*;
#(
  parameter int N    = 16,
  parameter int CNTW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   start,
  input  logic [NTERMS*N-1:0]    smp_in,
  output logic                   load,
  output logic                   step,
  output logic                   busy,
  output logic [CNTW-1:0]        cnt,
  output logic [NTERMS-1:0]      slice,
  output logic                   sign_slice,
  output logic                   done
);

  localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

  logic [N-1:0]    sreg_q [NTERMS];
  logic [N-1:0]    sreg_d [NTERMS];
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic            last;

  // control strobes
  always_comb begin
    load = start && !busy_q && !clr;
    step = busy_q && !clr;
    last = step && (cnt_q == LAST);
  end

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = last;
    for (int k = 0; k < NTERMS; k++) begin
      sreg_d[k] = sreg_q[k];
      if (load)
        sreg_d[k] = smp_in[k*N +: N];
      else if (step)
        sreg_d[k] = sreg_q[k] >> 1;
    end
    if (clr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + CNTW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      for (int k = 0; k < NTERMS; k++) sreg_q[k] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      for (int k = 0; k < NTERMS; k++) sreg_q[k] <= sreg_d[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NTERMS; k++) slice[k] = sreg_q[k][0];
    sign_slice = (cnt_q == LAST);
    busy       = busy_q;
    cnt        = cnt_q;
    done       = done_q;
  end

endmodule

// File: rtl/obc_da_pgen.sv
module obc_da_pgen
  import obc_da_pkg::*;
#(
  parameter gen_e GEN = GEN_HALF_TABLE,
  parameter int   CW  = 8,
  parameter int   PW  = CW + 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NTERMS*CW-1:0]       coef_in,
  input  logic [NTERMS-1:0]          slice,
  input  logic                       sign_slice,
  output logic signed [PW-1:0]       part
);

  localparam int EXT  = PW - CW;
  localparam int HALF = 2 ** (NTERMS - 1);
  localparam int HB   = NTERMS / 2;
  localparam int BANK = 2 ** HB;

  logic signed [CW-1:0] a [NTERMS];
  logic [NTERMS-1:0]    u;

  for (genvar k = 0; k < NTERMS; k++) begin : g_unpack
    assign a[k] = coef_in[k*CW +: CW];
  end

  // offset-binary digits: bit value, reversed on the sign slice
  assign u = slice ^ {NTERMS{sign_slice}};

  function automatic logic signed [PW-1:0] sx(input logic signed [CW-1:0] v);
    return {{EXT{v[CW-1]}}, v};
  endfunction

  function automatic logic signed [PW-1:0] pm(input logic sel,
                                              input logic signed [CW-1:0] v);
    return sel ? sx(v) : -sx(v);
  endfunction

  if (GEN == GEN_HALF_TABLE) begin : g_half
    logic signed [PW-1:0] tbl_q [HALF];
    logic signed [PW-1:0] tbl_d [HALF];
    logic [NTERMS-2:0]    idx;
    logic signed [PW-1:0] mag;

    // entries for top digit -1 only; the other half is the negated mirror
    always_comb begin
      for (int m = 0; m < HALF; m++) begin
        tbl_d[m] = tbl_q[m];
        if (load) begin
          tbl_d[m] = -sx(a[NTERMS-1]);
          for (int k = 0; k < NTERMS - 1; k++)
            tbl_d[m] = tbl_d[m] + pm(((m >> k) & 1) != 0, a[k]);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int m = 0; m < HALF; m++) tbl_q[m] <= '0;
      end else begin
        for (int m = 0; m < HALF; m++) tbl_q[m] <= tbl_d[m];
      end
    end

    always_comb begin
      idx  = u[NTERMS-1] ? ~u[NTERMS-2:0] : u[NTERMS-2:0];
      mag  = tbl_q[idx];
      part = u[NTERMS-1] ? -mag : mag;
    end

  end else if (GEN == GEN_TWO_BANK) begin : g_bank
    logic signed [PW-1:0] lo_q [BANK];
    logic signed [PW-1:0] lo_d [BANK];
    logic signed [PW-1:0] hi_q [BANK];
    logic signed [PW-1:0] hi_d [BANK];

    always_comb begin
      for (int m = 0; m < BANK; m++) begin
        lo_d[m] = lo_q[m];
        hi_d[m] = hi_q[m];
        if (load) begin
          lo_d[m] = '0;
          hi_d[m] = '0;
          for (int k = 0; k < HB; k++) begin
            lo_d[m] = lo_d[m] + pm(((m >> k) & 1) != 0, a[k]);
            hi_d[m] = hi_d[m] + pm(((m >> k) & 1) != 0, a[HB + k]);
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int m = 0; m < BANK; m++) begin
          lo_q[m] <= '0;
          hi_q[m] <= '0;
        end
      end else begin
        for (int m = 0; m < BANK; m++) begin
          lo_q[m] <= lo_d[m];
          hi_q[m] <= hi_d[m];
        end
      end
    end

    assign part = lo_q[u[HB-1:0]] + hi_q[u[NTERMS-1:HB]];

  end else begin : g_tree
    logic signed [CW-1:0] c_q [NTERMS];
    logic signed [CW-1:0] c_d [NTERMS];
    logic signed [PW-1:0] s   [NTERMS];
    logic signed [PW-1:0] sum_lo, sum_hi;

    always_comb begin
      for (int k = 0; k < NTERMS; k++) c_d[k] = load ? a[k] : c_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NTERMS; k++) c_q[k] <= '0;
      end else begin
        for (int k = 0; k < NTERMS; k++) c_q[k] <= c_d[k];
      end
    end

    // two-level adder tree of signed terms
    always_comb begin
      for (int k = 0; k < NTERMS; k++) s[k] = pm(u[k], c_q[k]);
      sum_lo = s[0] + s[1];
      sum_hi = s[2] + s[3];
      part   = sum_lo + sum_hi;
    end
  end

endmodule

// File: rtl/obc_da_acc.sv
module obc_da_acc
  import obc_da_pkg::*;
#(
  parameter int CW = 8,
  parameter int N  = 16,
  parameter int PW = CW + 3,
  parameter int RW = CW + N + 2,
  parameter int AW = RW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   load,
  input  logic                   step,
  input  logic [NTERMS*CW-1:0]   coef_in,
  input  logic signed [PW-1:0]   part,
  output logic signed [RW-1:0]   result
);

  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] csum;
  logic signed [AW:0]   wide;

  // offset: minus the coefficient sum, placed at the slice weight
  always_comb begin
    csum = '0;
    for (int k = 0; k < NTERMS; k++)
      csum = csum + AW'($signed(coef_in[k*CW +: CW]));
  end

  always_comb begin
    wide  = (AW+1)'(acc_q) + ((AW+1)'(part) <<< N);
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (load)
      acc_d = -(csum <<< N);
    else if (step)
      acc_d = AW'(wide >>> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // accumulator holds twice the product
  assign result = RW'(acc_q >>> 1);

endmodule

// File: rtl/obc_da_mac.sv
module obc_da_mac
  import obc_da_pkg::*;
#(
  parameter gen_e GEN = GEN_HALF_TABLE,
  parameter int   CW  = 8,
  parameter int   N   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    start,
  input  logic [NTERMS*CW-1:0]    coef_i,
  input  logic [NTERMS*N-1:0]     smp_i,
  output logic [CW+N+1:0]         result_o,
  output logic                    done_o
);

  localparam int PW   = CW + 3;
  localparam int RW   = CW + N + 2;
  localparam int AW   = RW + 1;
  localparam int CNTW = (N > 1) ? $clog2(N) : 1;

  logic                   load, step, busy, sign_slice;
  logic [CNTW-1:0]        cnt;
  logic [NTERMS-1:0]      slice_bits;
  logic signed [PW-1:0]   part;
  logic signed [RW-1:0]   acc_res;

  obc_da_seq #(.N(N), .CNTW(CNTW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .start      (start),
    .smp_in     (smp_i),
    .load       (load),
    .step       (step),
    .busy       (busy),
    .cnt        (cnt),
    .slice      (slice_bits),
    .sign_slice (sign_slice),
    .done       (done_o)
  );

  obc_da_pgen #(.GEN(GEN), .CW(CW), .PW(PW)) u_pgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .coef_in    (coef_i),
    .slice      (slice_bits),
    .sign_slice (sign_slice),
    .part       (part)
  );

  obc_da_acc #(.CW(CW), .N(N), .PW(PW), .RW(RW), .AW(AW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (load),
    .step    (step),
    .coef_in (coef_i),
    .part    (part),
    .result  (acc_res)
  );

  assign result_o = acc_res;

endmodule

// File: rtl/obc_da_mac_chk.sv
module obc_da_mac_chk
  import obc_da_pkg::*;
#(
  parameter int CW = 8,
  parameter int N  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  start,
  input logic                  busy,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0] cnt,
  input logic [NTERMS-1:0]     slice,
  input logic                  sgn,
  input logic signed [CW+2:0]  part,
  input logic [NTERMS*CW-1:0]  coef_in,
  input logic                  done,
  input logic [CW+N+1:0]       result
);

  localparam int PW   = CW + 3;
  localparam int CNTW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

  logic [NTERMS*CW-1:0] cref_q;
  logic signed [PW-1:0] ref_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cref_q <= '0;
    else if (start && !busy && !clr)   cref_q <= coef_in;
  end

  // independent slice value from own coefficient copy
  always_comb begin
    ref_p = '0;
    for (int k = 0; k < NTERMS; k++) begin
      if (slice[k] ^ sgn) ref_p = ref_p + PW'($signed(cref_q[k*CW +: CW]));
      else                ref_p = ref_p - PW'($signed(cref_q[k*CW +: CW]));
    end
  end

  a_r4_slice_value: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> part == ref_p);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && $past(cnt) == LAST);

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> result == '0 && !done && !busy);

  a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clr && cnt != LAST |=> busy && cnt == $past(cnt) + CNTW'(1));

endmodule

bind obc_da_mac obc_da_mac_chk #(.CW(CW), .N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr),
  .start   (start),
  .busy    (busy),
  .cnt     (cnt),
  .slice   (slice_bits),
  .sgn     (sign_slice),
  .part    (part),
  .coef_in (coef_i),
  .done    (done_o),
  .result  (result_o)
);

// File: tb/obc_da_mac_bench.sv
module obc_da_mac_bench;
  import obc_da_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int N  = 16;
  localparam int NT = 4;
  localparam int RW = CW + N + 2;
  localparam int NV = 12;
  localparam int NLOOP = 10;

  localparam int VA [NV][NT] = '{
    '{2, 3, 4, 5}, '{2, 3, 4, 5}, '{-1, -1, -1, -1}, '{127, -128, 1, -1},
    '{-128, -128, -128, -128}, '{-128, -128, -128, -128}, '{3, 5, 7, -9},
    '{0, 0, 0, 0}, '{1, 0, 0, 0}, '{127, 127, 127, 127},
    '{-7, 9, -11, 13}, '{2, 3, 4, 5}};
  localparam int VX [NV][NT] = '{
    '{1, 2, 3, 4}, '{0, 0, 0, 0}, '{-1, -1, -1, -1}, '{32767, -32768, -1, 1},
    '{-32768, -32768, -32768, -32768}, '{32767, 32767, 32767, 32767},
    '{1234, -4321, 77, -1}, '{12345, -2222, 7, -9}, '{-32768, 0, 0, 0},
    '{32767, -32768, 21845, -21846}, '{-300, 5000, -1, 31000}, '{-1, -1, -1, -1}};

  logic clk, rst_n, clr, start;
  logic [NT*CW-1:0] coef;
  logic [NT*N-1:0]  smp;
  logic [RW-1:0]    res_h, res_b, res_t;
  logic             done_h, done_b, done_t;
  int checks, fails;

  obc_da_mac #(.GEN(GEN_HALF_TABLE), .CW(CW), .N(N)) u_obc_da_mac (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .coef_i(coef),
    .smp_i(smp), .result_o(res_h), .done_o(done_h));
  obc_da_mac #(.GEN(GEN_TWO_BANK), .CW(CW), .N(N)) u_obc_da_mac_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .coef_i(coef),
    .smp_i(smp), .result_o(res_b), .done_o(done_b));
  obc_da_mac #(.GEN(GEN_ADDER_TREE), .CW(CW), .N(N)) u_obc_da_mac_tree (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .coef_i(coef),
    .smp_i(smp), .result_o(res_t), .done_o(done_t));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint expect_ip(input int v);
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(VA[v][k]) * longint'(VX[v][k]);
    return s;
  endfunction

  function automatic string row_tag(input int v);
    case (v)
      0: return "R4";
      1: return "R8";
      2, 5, 8: return "R3";
      3, 4, 6: return "R9";
      9: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_results(input string req, input longint exp);
    check({req, " R1 half"}, longint'($signed(res_h)), exp);
    check({req, " R5 bank"}, longint'($signed(res_b)), exp);
    check({req, " R5 tree"}, longint'($signed(res_t)), exp);
  endtask

  task automatic set_row(input int v);
    for (int k = 0; k < NT; k++) begin
      coef[k*CW +: CW] = VA[v][k][CW-1:0];
      smp[k*N +: N]    = VX[v][k][N-1:0];
    end
  endtask

  // mode 0 plain, 1 second start mid-run (R7), 2 inputs change mid-run (R10)
  task automatic run(input int v, input int mode);
    int seen;
    @(negedge clk);
    set_row(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= N; c++) begin
      @(negedge clk);
      if (mode == 2 && c == 1) set_row(9);
      if (mode == 1 && c == 4) begin
        set_row(11);
        start = 1'b1;
      end
      if (mode == 1 && c == 5) start = 1'b0;
      if (c == N - 1)
        check("R2 done early", longint'({done_h, done_b, done_t}), 0);
      if (c == N)
        check("R2 done on time", longint'({done_h, done_b, done_t}), 7);
    end
    case (mode)
      1: check_results("R7", expect_ip(v));
      2: check_results("R10", expect_ip(v));
      default: check_results(row_tag(v), expect_ip(v));
    endcase
    @(negedge clk);
    check("R2 done pulse width", longint'({done_h, done_b, done_t}), 0);
    if (mode == 1) begin
      seen = 0;
      for (int c = 0; c < N + 4; c++) begin
        @(negedge clk);
        if (done_h || done_b || done_t) seen++;
      end
      check("R7 no second completion", seen, 0);
      check_results("R7 held", expect_ip(v));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seen;
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    clr = 1'b0;
    start = 1'b0;
    coef = '0;
    smp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check_results("R11", 0);
    check("R11 done low", longint'({done_h, done_b, done_t}), 0);

    // table walk
    for (int v = 0; v < NLOOP; v++) run(v, 0);

    // R7: start while busy is ignored
    run(0, 1);
    // R10: inputs change after capture
    run(10, 2);

    // R6: clear mid-run aborts with no completion
    @(negedge clk);
    set_row(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check_results("R6 cleared", 0);
    seen = 0;
    for (int c = 0; c < N + 2; c++) begin
      @(negedge clk);
      if (done_h || done_b || done_t) seen++;
    end
    check("R6 no completion after clear", seen, 0);
    check_results("R6 stays zero", 0);

    // R6: clear while idle wipes a held result; R2 hold before that
    run(6, 0);
    repeat (3) @(negedge clk);
    check_results("R2 held", expect_ip(6));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check_results("R6 idle clear", 0);

    // R8: zero samples after nonzero run
    run(1, 0);
    finish_run();
  end

endmodule